// File: doc/BRIEF.md
# Paged Microcode Sequencer

This block forms the microcode address for a microprogrammed processor that can run more than one instruction set. The address joins three fields: a 4-bit page number, which selects the instruction set, the 8-bit opcode held in an instruction register, and a 4-bit step counter. Each opcode therefore owns a fixed slot of sixteen microinstructions inside its page.

The external microcode store returns a 24-bit word for the current address. The sequencer registers that word as the control word for the following cycle. An opcode enters the sequencer in one of two ways: an explicit load strobe, or an automatic fetch that follows an end-of-instruction signal.

Software can write a new page number at any time. The write is staged and takes effect only at the next opcode load, so the instruction that is already running finishes under its own instruction set. Routines that need more than sixteen steps, or that wrap past the last step, simply continue in the same slot.

Top module: `ucseq_top`

## Requirements
- R1: While reset is low, and after it is released, the page, instruction register and step are all 0, so the address is 0, and the control word holds the no-operation value (default 24'h000000). A page write that was staged before reset is discarded.
- R2: The address output is {page[3:0], opcode[7:0], step[3:0]}: the page occupies bits 15:12, the opcode bits 11:4 and the step bits 3:0. The step output equals bits 3:0.
- R3: When the load strobe is high at a clock edge, the instruction register takes the opcode input and the step becomes 0 at that edge.
- R4: At any edge without a load, the step increases by one. From 15 it wraps to 0, and the opcode and page keep their values.
- R5: When end-of-instruction is high at an edge, the next edge performs a load of the opcode input even though the load strobe is low.
- R6: A page write with no load at the same edge leaves the address page field unchanged until the next load.
- R7: A page write at the same edge as a load applies its value at that load.
- R8: When several page writes come before a load, the last one written becomes the page at that load.
- R9: The control word output equals the microcode word that was presented for the address of the previous cycle.
- R10: A load together with end-of-instruction loads at once and loads again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 8 | Opcode byte from the data bus |
| op_load_i | input | 1 | Load the opcode into the instruction register |
| end_i | input | 1 | End of instruction; requests a fetch at the next edge |
| page_wr_i | input | 1 | Page write strobe |
| page_i | input | 4 | Page number to stage |
| uc_data_i | input | 24 | Microcode word read at uaddr_o |
| uaddr_o | output | 16 | Microcode address {page, opcode, step} |
| step_o | output | 4 | Current step within the opcode slot |
| cw_o | output | 24 | Registered control word |

## Verification
Two events can meet in one cycle. A page write can land on the same edge as an opcode load, and a load can coincide with end-of-instruction. The vector walk provokes both cases by asserting the two strobes together. For the page case, the page field read back at the address output must already carry the new value after that edge. For the load case, the opcode input must be reloaded with step 0 on the following edge as well. The same walk also keeps a write that is not accompanied by a load apart from the load, and checks that the page field holds its old value until that load arrives.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    parameter int PAGE_W = 4;
    parameter int OP_W   = 8;
    parameter int STEP_W = 4;
    parameter int ADDR_W = PAGE_W + OP_W + STEP_W;

    // Page selection: the active page plus one staged write
    typedef struct packed {
        logic [PAGE_W-1:0] active;
        logic [PAGE_W-1:0] staged;
        logic              staged_vld;
    } page_st_t;

    // Opcode slot: instruction register, step counter, fetch request
    typedef struct packed {
        logic [OP_W-1:0]   ir;
        logic [STEP_W-1:0] step;
        logic              fetch;
    } slot_st_t;

endpackage

// File: rtl/ucseq_page.sv
module ucseq_page
    import ucseq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wdata_i,
    input  logic              load_i,
    output logic [PAGE_W-1:0] page_o
);

    page_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // a write in the same cycle as a load wins over the staged value
            if (wr_i) begin
                st_d.active = wdata_i;
            end else if (st_q.staged_vld) begin
                st_d.active = st_q.staged;
            end
            st_d.staged_vld = 1'b0;
        end else if (wr_i) begin
            st_d.staged     = wdata_i;
            st_d.staged_vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_o = st_q.active;

endmodule

// File: rtl/ucseq_slot.sv
module ucseq_slot
    import ucseq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              op_load_i,
    input  logic              end_i,
    output logic [OP_W-1:0]   ir_o,
    output logic [STEP_W-1:0] step_o,
    output logic              load_o
);

    slot_st_t st_d, st_q;
    logic     load;

    // explicit strobe, or the fetch requested by end-of-instruction
    assign load = op_load_i | st_q.fetch;

    always_comb begin
        st_d       = st_q;
        st_d.fetch = end_i;
        if (load) begin
            st_d.ir   = opcode_i;
            st_d.step = '0;
        end else begin
            st_d.step = st_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ir_o   = st_q.ir;
    assign step_o = st_q.step;
    assign load_o = load;

endmodule

// File: rtl/ucseq_cwreg.sv
module ucseq_cwreg #(
    parameter int              CW_W   = 24,
    parameter logic [CW_W-1:0] CW_NOP = '0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [CW_W-1:0] data_i,
    output logic [CW_W-1:0] cw_o
);

    logic [CW_W-1:0] cw_d, cw_q;

    always_comb begin
        cw_d = data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cw_q <= CW_NOP;
        end else begin
            cw_q <= cw_d;
        end
    end

    assign cw_o = cw_q;

endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
    import ucseq_pkg::*;
#(
    parameter int              CW_W   = 24,
    parameter logic [CW_W-1:0] CW_NOP = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              op_load_i,
    input  logic              end_i,
    input  logic              page_wr_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [CW_W-1:0]   uc_data_i,
    output logic [ADDR_W-1:0] uaddr_o,
    output logic [STEP_W-1:0] step_o,
    output logic [CW_W-1:0]   cw_o
);

    logic [PAGE_W-1:0] page;
    logic [OP_W-1:0]   ir;
    logic [STEP_W-1:0] step;
    logic              do_load;

    ucseq_slot u_slot (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .opcode_i  (opcode_i),
        .op_load_i (op_load_i),
        .end_i     (end_i),
        .ir_o      (ir),
        .step_o    (step),
        .load_o    (do_load)
    );

    ucseq_page u_page (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (page_wr_i),
        .wdata_i (page_i),
        .load_i  (do_load),
        .page_o  (page)
    );

    ucseq_cwreg #(
        .CW_W   (CW_W),
        .CW_NOP (CW_NOP)
    ) u_cw (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .data_i (uc_data_i),
        .cw_o   (cw_o)
    );

    assign uaddr_o = {page, ir, step};
    assign step_o  = step;

endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk
    import ucseq_pkg::*;
#(
    parameter int CW_W = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [OP_W-1:0]   opcode_i,
    input logic              op_load_i,
    input logic              end_i,
    input logic [CW_W-1:0]   uc_data_i,
    input logic [ADDR_W-1:0] uaddr_o,
    input logic [STEP_W-1:0] step_o,
    input logic [CW_W-1:0]   cw_o,
    input logic              do_load
);

    localparam int OP_LO = STEP_W;
    localparam int OP_HI = STEP_W + OP_W - 1;
    localparam int PG_LO = STEP_W + OP_W;

    AST_LOAD_STEP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_load_i |=> (step_o == '0)); // R3

    AST_LOAD_TAKES_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_load_i |=> (uaddr_o[OP_HI:OP_LO] == $past(opcode_i))); // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !do_load |=> (step_o == STEP_W'($past(step_o) + 1'b1))); // R4

    AST_END_REFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        end_i |=> ##1 (step_o == '0)); // R5

    AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !do_load |=> $stable(uaddr_o[ADDR_W-1:PG_LO])); // R6

    AST_CW_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cw_o == $past(uc_data_i))); // R9

endmodule

bind ucseq_top ucseq_chk #(.CW_W(CW_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .opcode_i  (opcode_i),
    .op_load_i (op_load_i),
    .end_i     (end_i),
    .uc_data_i (uc_data_i),
    .uaddr_o   (uaddr_o),
    .step_o    (step_o),
    .cw_o      (cw_o),
    .do_load   (do_load)
);

// File: tb/ucseq_top_bench.sv
module ucseq_top_bench;

    localparam logic [23:0] NOP = 24'h000000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic        op_load_i = 1'b0;
    logic        end_i = 1'b0;
    logic        page_wr_i = 1'b0;
    logic [3:0]  page_i = '0;
    logic [23:0] uc_data_i;
    logic [15:0] uaddr_o;
    logic [3:0]  step_o;
    logic [23:0] cw_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    // microcode store model: a word computed from its address
    function automatic logic [23:0] mem_word(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8], ~a[7:0]};
    endfunction

    assign uc_data_i = mem_word(uaddr_o);

    ucseq_top u_ucseq_top (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .opcode_i  (opcode_i),
        .op_load_i (op_load_i),
        .end_i     (end_i),
        .page_wr_i (page_wr_i),
        .page_i    (page_i),
        .uc_data_i (uc_data_i),
        .uaddr_o   (uaddr_o),
        .step_o    (step_o),
        .cw_o      (cw_o)
    );

    typedef struct packed {
        logic       ld;
        logic [7:0] op;
        logic       en;
        logic       pw;
        logic [3:0] pg;
        logic [3:0] e_pg;
        logic [7:0] e_ir;
        logic [3:0] e_st;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h3C, 1'b0, 1'b0, 4'h0, 4'h0, 8'h3C, 4'h0, 4'd3},  // R3
        '{1'b0, 8'h00, 1'b0, 1'b0, 4'h0, 4'h0, 8'h3C, 4'h1, 4'd4},  // R4
        '{1'b0, 8'h00, 1'b0, 1'b1, 4'h5, 4'h0, 8'h3C, 4'h2, 4'd6},  // R6
        '{1'b0, 8'h00, 1'b0, 1'b0, 4'h0, 4'h0, 8'h3C, 4'h3, 4'd6},  // R6
        '{1'b0, 8'h00, 1'b0, 1'b1, 4'h7, 4'h0, 8'h3C, 4'h4, 4'd6},  // R6
        '{1'b1, 8'hA1, 1'b0, 1'b0, 4'h0, 4'h7, 8'hA1, 4'h0, 4'd8},  // R8
        '{1'b0, 8'h00, 1'b0, 1'b0, 4'h0, 4'h7, 8'hA1, 4'h1, 4'd2},  // R2
        '{1'b0, 8'h00, 1'b1, 1'b0, 4'h0, 4'h7, 8'hA1, 4'h2, 4'd5},  // R5
        '{1'b0, 8'h42, 1'b0, 1'b0, 4'h0, 4'h7, 8'h42, 4'h0, 4'd5},  // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 4'h0, 4'h7, 8'h42, 4'h1, 4'd4},  // R4
        '{1'b1, 8'h10, 1'b0, 1'b1, 4'h2, 4'h2, 8'h10, 4'h0, 4'd7},  // R7
        '{1'b1, 8'h11, 1'b1, 1'b0, 4'h0, 4'h2, 8'h11, 4'h0, 4'd10}, // R10
        '{1'b0, 8'h12, 1'b0, 1'b0, 4'h0, 4'h2, 8'h12, 4'h0, 4'd10}, // R10
        '{1'b0, 8'h00, 1'b0, 1'b0, 4'h0, 4'h2, 8'h12, 4'h1, 4'd4}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    task automatic idle_inputs();
        op_load_i = 1'b0;
        end_i     = 1'b0;
        page_wr_i = 1'b0;
        opcode_i  = '0;
        page_i    = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] prev;
        logic [15:0] exp_addr;

        // R1: reset state
        tick();
        chk("R1 addr in reset", 32'(uaddr_o), 32'h0);
        chk("R1 cw in reset", 32'(cw_o), 32'(NOP));
        rst_ni = 1'b1;
        #1;
        chk("R1 addr after release", 32'(uaddr_o), 32'h0);

        prev = 16'h0000;
        for (int i = 0; i < NV; i++) begin
            op_load_i = VECS[i].ld;
            opcode_i  = VECS[i].op;
            end_i     = VECS[i].en;
            page_wr_i = VECS[i].pw;
            page_i    = VECS[i].pg;
            tick();
            idle_inputs();
            exp_addr = {VECS[i].e_pg, VECS[i].e_ir, VECS[i].e_st};
            chk($sformatf("R%0d vec %0d addr", VECS[i].req, i), 32'(uaddr_o), 32'(exp_addr));
            chk($sformatf("R2 vec %0d step", i), 32'(step_o), 32'(VECS[i].e_st));
            chk($sformatf("R9 vec %0d cw", i), 32'(cw_o), 32'(mem_word(prev)));
            prev = exp_addr;
        end

        // R4: run to step 15 and wrap to 0 in the same slot
        for (int k = 0; k < 14; k++) tick();
        chk("R4 step 15", 32'(uaddr_o), 32'h212F);
        tick();
        chk("R4 wrap", 32'(uaddr_o), 32'h2120);
        chk("R9 cw after wrap", 32'(cw_o), 32'(mem_word(16'h212F)));

        // R1: reset mid-run discards a staged page
        page_wr_i = 1'b1;
        page_i    = 4'h9;
        tick();
        idle_inputs();
        rst_ni = 1'b0;
        #1;
        chk("R1 addr after mid reset", 32'(uaddr_o), 32'h0);
        chk("R1 cw after mid reset", 32'(cw_o), 32'(NOP));
        tick();
        rst_ni = 1'b1;
        #1;
        op_load_i = 1'b1;
        opcode_i  = 8'h77;
        tick();
        idle_inputs();
        chk("R1 staged page dropped", 32'(uaddr_o), 32'h0770);

        // R3: back-to-back loads each restart at step 0
        op_load_i = 1'b1;
        opcode_i  = 8'hFF;
        tick();
        chk("R3 back to back", 32'(uaddr_o), 32'h0FF0);
        opcode_i  = 8'h01;
        tick();
        idle_inputs();
        chk("R3 second load", 32'(uaddr_o), 32'h0010);

        finish_run();
    end

endmodule